// File: doc/BRIEF.md
# Issue Scoreboard Hazard Controller

This block is the central bookkeeping for a small out-of-order execution core. It serves five execution units: an integer unit (1), two floating-point multipliers (2 and 3), a floating-point adder (4) and a divider (5). A decoded instruction arrives on a valid/ready stream. The stream carries the target unit number, an operation code, a destination register and two source registers. The controller accepts instructions strictly in order. It then tells each unit when its operands may be read and when its result may be written back.

Decode is split into two steps. The first step is issue, which checks for structural and output (write-after-write) hazards. The second step is operand read, which waits until every true dependency has been written back. There is no forwarding path, so a consumer can read a register only after its producer has written it back. A unit reports the end of its computation with a one-cycle done pulse. The unit's write-back is then held while any other waiting instruction still has to read the old value of the destination register. This rule prevents write-after-read hazards.

Stream rules: an instruction moves on a rising edge where `iss_valid` and `iss_ready` are both high. `iss_ready` reflects the instruction currently presented and may be low for any number of cycles. While it is low, the source must hold the instruction stable with `iss_valid` high. The controller never drops or reorders a presented instruction. The read and write-back grants are plain one-cycle pulses, and the done inputs are plain one-cycle pulses.

Top module: `issue_scoreboard`

## Requirements
- R1: `iss_ready` is high exactly when `iss_unit` is between 1 and 5, that unit is idle, and no in-flight instruction targets `iss_dst`. Codes 0, 6 and 7 are never accepted. A held instruction transfers on the first edge where it is ready, and it has no effect on any unit before that edge.
- R2: An instruction whose target unit is busy is not accepted. A different idle unit stays acceptable in the same cycle.
- R3: An instruction whose destination is already the destination of an uncompleted instruction is not accepted (write-after-write stall).
- R4: Bit u-1 of `rd_grant` pulses for exactly one cycle once both sources of unit u have no pending producer. If no producer is pending at issue, the pulse comes in the cycle after issue. Otherwise it comes in the cycle after the last producer's write-back grant.
- R5: Several units whose operands become available in the same cycle receive their read grants in that same cycle.
- R6: A done pulse for a unit is honoured only after that unit's read grant. A done pulse for an idle unit, or for a unit still waiting for operands, has no effect.
- R7: In the cycle after an honoured done pulse, the unit receives a one-cycle `wb_grant` if nothing blocks it. At the same time `wb_dst` shows its destination register.
- R8: A unit's write-back is withheld while another unit has been issued but not yet granted its read, and that unit has a source equal to this destination whose producer is no longer pending. The write-back is released in the cycle after that read grant.
- R9: When several units are eligible for write-back in the same cycle, only the lowest-numbered one is granted. The others follow in later cycles in ascending order.
- R10: In the cycle after its write-back grant, a unit accepts a new instruction, and its destination register no longer stalls issue.
- R11: If an instruction is accepted in the same cycle as the write-back grant of one of its producers, that operand counts as available. The read grant then follows in the next cycle.
- R12: After reset no unit is busy, no register is pending, and both `rd_grant` and `wb_grant` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | An instruction is presented |
| iss_ready | output | 1 | The presented instruction can be accepted |
| iss_unit | input | 3 | Target unit number, 1 to 5 |
| iss_op | input | 4 | Operation code, latched for the unit |
| iss_dst | input | 4 | Destination register |
| iss_src1 | input | 4 | First source register |
| iss_src2 | input | 4 | Second source register |
| rd_grant | output | 5 | Per-unit operand read pulse, bit u-1 for unit u |
| exe_done | input | 5 | Per-unit completion pulse |
| wb_grant | output | 5 | Per-unit write-back pulse, at most one bit set |
| wb_dst | output | 4 | Destination register of the granted write-back |
| unit_op | output | 20 | Latched operation of each unit, unit u in bits 4u-1 down to 4u-4 |

## Verification
The bench builds the controller with its defaults: five units, sixteen registers, 3-bit producer tags and 4-bit operation codes. With five units, the integer, both multipliers, the adder and the divider can all be in flight together. A 3-bit unit code also leaves the illegal codes 0, 6 and 7 within reach for the acceptance check. The directed scenarios cover several cases. One is a divide, an add waiting on the divide, and a subtract overwriting the add's second source, which exposes the write-after-read hold. The others are simultaneous completions, simultaneous operand release, ignored done pulses, and an issue that coincides with its producer's write-back.

// File: rtl/isb_pkg.sv
`timescale 1ns/1ps
package isb_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_OPS  = 2'd1,
    PH_EXEC = 2'd2,
    PH_WB   = 2'd3
  } slot_phase_t;
endpackage

// File: rtl/isb_result_table.sv
`timescale 1ns/1ps
module isb_result_table #(
  parameter int NUM_REGS = 16,
  parameter int REG_W    = 4,
  parameter int TAG_W    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en,
  input  logic [REG_W-1:0] set_reg,
  input  logic [TAG_W-1:0] set_tag,
  input  logic             clr_en,
  input  logic [REG_W-1:0] clr_reg,
  output logic [TAG_W-1:0] pend [NUM_REGS]
);
  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pend[r] <= '0;
      end else if (set_en && set_reg == REG_W'(r)) begin
        pend[r] <= set_tag;
      end else if (clr_en && clr_reg == REG_W'(r)) begin
        pend[r] <= '0;
      end
    end
  end
endmodule

// File: rtl/isb_unit_slot.sv
`timescale 1ns/1ps
module isb_unit_slot
  import isb_pkg::*;
#(
  parameter int REG_W = 4,
  parameter int TAG_W = 3,
  parameter int OP_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc,
  input  logic [OP_W-1:0]  a_op,
  input  logic [REG_W-1:0] a_dst,
  input  logic [REG_W-1:0] a_s1,
  input  logic [REG_W-1:0] a_s2,
  input  logic [TAG_W-1:0] a_q1,
  input  logic [TAG_W-1:0] a_q2,
  input  logic             rd_fire,
  input  logic             exe_done,
  input  logic             wb_fire,
  input  logic [TAG_W-1:0] wb_tag,
  output logic             busy,
  output logic             rd_ok,
  output logic             wb_pend,
  output logic [OP_W-1:0]  op,
  output logic [REG_W-1:0] dst,
  output logic [REG_W-1:0] s1,
  output logic [REG_W-1:0] s2,
  output logic             r1,
  output logic             r2
);
  slot_phase_t     phase;
  logic [TAG_W-1:0] q1, q2;
  logic [TAG_W-1:0] q1_in, q2_in;

  // a producer writing back in the allocation cycle is no longer pending
  assign q1_in = (a_q1 == wb_tag) ? '0 : a_q1;
  assign q2_in = (a_q2 == wb_tag) ? '0 : a_q2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      op    <= '0;
      dst   <= '0;
      s1    <= '0;
      s2    <= '0;
      q1    <= '0;
      q2    <= '0;
      r1    <= 1'b0;
      r2    <= 1'b0;
    end else begin
      case (phase)
        PH_IDLE: begin
          if (alloc) begin
            phase <= PH_OPS;
            op    <= a_op;
            dst   <= a_dst;
            s1    <= a_s1;
            s2    <= a_s2;
            q1    <= q1_in;
            q2    <= q2_in;
            r1    <= (q1_in == '0);
            r2    <= (q2_in == '0);
          end
        end
        PH_OPS: begin
          if (rd_fire) begin
            phase <= PH_EXEC;
            r1    <= 1'b0;
            r2    <= 1'b0;
          end else begin
            if (!r1 && wb_tag != '0 && q1 == wb_tag) begin
              r1 <= 1'b1;
              q1 <= '0;
            end
            if (!r2 && wb_tag != '0 && q2 == wb_tag) begin
              r2 <= 1'b1;
              q2 <= '0;
            end
          end
        end
        PH_EXEC: begin
          if (exe_done) phase <= PH_WB;
        end
        default: begin
          if (wb_fire) phase <= PH_IDLE;
        end
      endcase
    end
  end

  assign busy    = (phase != PH_IDLE);
  assign rd_ok   = (phase == PH_OPS) && r1 && r2;
  assign wb_pend = (phase == PH_WB);
endmodule

// File: rtl/isb_wb_arbiter.sv
`timescale 1ns/1ps
module isb_wb_arbiter #(
  parameter int NUM_UNITS = 5,
  parameter int TAG_W     = 3
) (
  input  logic [NUM_UNITS-1:0] req,
  output logic [NUM_UNITS-1:0] gnt,
  output logic [TAG_W-1:0]     tag
);
  logic found;
  always_comb begin
    gnt   = '0;
    tag   = '0;
    found = 1'b0;
    for (int i = 0; i < NUM_UNITS; i++) begin
      if (req[i] && !found) begin
        gnt[i] = 1'b1;
        tag    = TAG_W'(i + 1);
        found  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/issue_scoreboard.sv
`timescale 1ns/1ps
module issue_scoreboard #(
  parameter int NUM_UNITS = 5,
  parameter int NUM_REGS  = 16,
  parameter int OP_W      = 4,
  localparam int REG_W    = $clog2(NUM_REGS),
  localparam int TAG_W    = $clog2(NUM_UNITS + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      iss_valid,
  output logic                      iss_ready,
  input  logic [TAG_W-1:0]          iss_unit,
  input  logic [OP_W-1:0]           iss_op,
  input  logic [REG_W-1:0]          iss_dst,
  input  logic [REG_W-1:0]          iss_src1,
  input  logic [REG_W-1:0]          iss_src2,
  output logic [NUM_UNITS-1:0]      rd_grant,
  input  logic [NUM_UNITS-1:0]      exe_done,
  output logic [NUM_UNITS-1:0]      wb_grant,
  output logic [REG_W-1:0]          wb_dst,
  output logic [NUM_UNITS*OP_W-1:0] unit_op
);
  logic [TAG_W-1:0] pend [NUM_REGS];
  logic [NUM_UNITS-1:0] u_busy, u_rdok, u_wbp, u_r1, u_r2, u_alloc;
  logic [NUM_UNITS-1:0] war_blk, wb_req;
  logic [REG_W-1:0] u_dst [NUM_UNITS];
  logic [REG_W-1:0] u_s1  [NUM_UNITS];
  logic [REG_W-1:0] u_s2  [NUM_UNITS];
  logic [TAG_W-1:0] wb_tag;
  logic             tgt_ok, tgt_busy, iss_fire;

  // issue acceptance
  always_comb begin
    tgt_ok   = 1'b0;
    tgt_busy = 1'b0;
    for (int i = 0; i < NUM_UNITS; i++) begin
      if (iss_unit == TAG_W'(i + 1)) begin
        tgt_ok   = 1'b1;
        tgt_busy = u_busy[i];
      end
    end
  end

  assign iss_ready = tgt_ok && !tgt_busy && (pend[iss_dst] == '0);
  assign iss_fire  = iss_valid && iss_ready;

  isb_result_table #(
    .NUM_REGS(NUM_REGS),
    .REG_W   (REG_W),
    .TAG_W   (TAG_W)
  ) i_table (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_en (iss_fire),
    .set_reg(iss_dst),
    .set_tag(iss_unit),
    .clr_en (|wb_grant),
    .clr_reg(wb_dst),
    .pend   (pend)
  );

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    assign u_alloc[u] = iss_fire && (iss_unit == TAG_W'(u + 1));

    isb_unit_slot #(
      .REG_W(REG_W),
      .TAG_W(TAG_W),
      .OP_W (OP_W)
    ) i_slot (
      .clk     (clk),
      .rst_n   (rst_n),
      .alloc   (u_alloc[u]),
      .a_op    (iss_op),
      .a_dst   (iss_dst),
      .a_s1    (iss_src1),
      .a_s2    (iss_src2),
      .a_q1    (pend[iss_src1]),
      .a_q2    (pend[iss_src2]),
      .rd_fire (u_rdok[u]),
      .exe_done(exe_done[u]),
      .wb_fire (wb_grant[u]),
      .wb_tag  (wb_tag),
      .busy    (u_busy[u]),
      .rd_ok   (u_rdok[u]),
      .wb_pend (u_wbp[u]),
      .op      (unit_op[u*OP_W +: OP_W]),
      .dst     (u_dst[u]),
      .s1      (u_s1[u]),
      .s2      (u_s2[u]),
      .r1      (u_r1[u]),
      .r2      (u_r2[u])
    );

    // hold write-back while another unit still needs the old value
    always_comb begin
      war_blk[u] = 1'b0;
      for (int f = 0; f < NUM_UNITS; f++) begin
        if (f != u && u_busy[f] &&
            ((u_r1[f] && u_s1[f] == u_dst[u]) ||
             (u_r2[f] && u_s2[f] == u_dst[u]))) begin
          war_blk[u] = 1'b1;
        end
      end
    end

    assign wb_req[u] = u_wbp[u] && !war_blk[u];
  end

  isb_wb_arbiter #(
    .NUM_UNITS(NUM_UNITS),
    .TAG_W    (TAG_W)
  ) i_arb (
    .req(wb_req),
    .gnt(wb_grant),
    .tag(wb_tag)
  );

  always_comb begin
    wb_dst = '0;
    for (int i = 0; i < NUM_UNITS; i++) begin
      if (wb_grant[i]) wb_dst = u_dst[i];
    end
  end

  assign rd_grant = u_rdok;
endmodule

// File: rtl/isb_checker.sv
`timescale 1ns/1ps
module isb_checker #(
  parameter int NUM_UNITS = 5,
  parameter int REG_W     = 4,
  parameter int TAG_W     = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 iss_valid,
  input logic                 iss_ready,
  input logic [TAG_W-1:0]     iss_unit,
  input logic [REG_W-1:0]     iss_dst,
  input logic [NUM_UNITS-1:0] rd_grant,
  input logic [NUM_UNITS-1:0] wb_grant
);
  logic [NUM_UNITS-1:0] sh_busy, sh_read;
  logic [REG_W-1:0]     sh_dst [NUM_UNITS];
  logic                 fire;

  assign fire = iss_valid && iss_ready;

  for (genvar i = 0; i < NUM_UNITS; i++) begin : g_sh
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        sh_busy[i] <= 1'b0;
        sh_read[i] <= 1'b0;
        sh_dst[i]  <= '0;
      end else begin
        if (fire && iss_unit == TAG_W'(i + 1)) begin
          sh_busy[i] <= 1'b1;
          sh_read[i] <= 1'b0;
          sh_dst[i]  <= iss_dst;
        end
        if (rd_grant[i]) sh_read[i] <= 1'b1;
        if (wb_grant[i]) sh_busy[i] <= 1'b0;
      end
    end

    a_r2_issue_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && iss_unit == TAG_W'(i + 1)) |-> !sh_busy[i]);

    a_r3_no_waw: assert property (@(posedge clk) disable iff (!rst_n)
      fire |-> !(sh_busy[i] && sh_dst[i] == iss_dst));

    a_r4_read_once: assert property (@(posedge clk) disable iff (!rst_n)
      rd_grant[i] |-> (sh_busy[i] && !sh_read[i]));

    a_r6_wb_after_read: assert property (@(posedge clk) disable iff (!rst_n)
      wb_grant[i] |-> (sh_busy[i] && sh_read[i]));

    a_r7_wb_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      wb_grant[i] |=> !wb_grant[i]);
  end

  a_r9_one_writer: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wb_grant));
endmodule

bind issue_scoreboard isb_checker #(
  .NUM_UNITS(NUM_UNITS),
  .REG_W    (REG_W),
  .TAG_W    (TAG_W)
) i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .iss_valid(iss_valid),
  .iss_ready(iss_ready),
  .iss_unit (iss_unit),
  .iss_dst  (iss_dst),
  .rd_grant (rd_grant),
  .wb_grant (wb_grant)
);

// File: tb/test_issue_scoreboard.sv
`timescale 1ns/1ps
module test_issue_scoreboard;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        iss_valid = 1'b0;
  logic        iss_ready;
  logic [2:0]  iss_unit = 3'd1;
  logic [3:0]  iss_op = 4'd0;
  logic [3:0]  iss_dst = 4'd0;
  logic [3:0]  iss_src1 = 4'd0;
  logic [3:0]  iss_src2 = 4'd0;
  logic [4:0]  rd_grant;
  logic [4:0]  exe_done = 5'd0;
  logic [4:0]  wb_grant;
  logic [3:0]  wb_dst;
  logic [19:0] unit_op;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  issue_scoreboard i_issue_scoreboard (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_ready(iss_ready),
    .iss_unit(iss_unit), .iss_op(iss_op), .iss_dst(iss_dst),
    .iss_src1(iss_src1), .iss_src2(iss_src2), .rd_grant(rd_grant),
    .exe_done(exe_done), .wb_grant(wb_grant), .wb_dst(wb_dst),
    .unit_op(unit_op)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic present(input logic [2:0] u, input logic [3:0] d, input logic [3:0] a, input logic [3:0] b);
    iss_unit = u; iss_dst = d; iss_src1 = a; iss_src2 = b; iss_op = {1'b0, u};
    #1;
  endtask

  // returns at the falling edge after the transfer edge
  task automatic issue(input logic [2:0] u, input logic [3:0] d, input logic [3:0] a, input logic [3:0] b);
    present(u, d, a, b);
    iss_valid = 1'b1;
    for (int k = 0; k < 50 && !iss_ready; k++) step();
    step();
    iss_valid = 1'b0;
  endtask

  task automatic done_pulse(input logic [4:0] m);
    exe_done = m;
    step();
    exe_done = 5'd0;
  endtask

  task automatic t_reset();
    chk("R12 rd_grant", rd_grant, 0);
    chk("R12 wb_grant", wb_grant, 0);
    present(3'd1, 4'd0, 4'd0, 4'd0);
    chk("R12 ready", iss_ready, 1);
    present(3'd0, 4'd0, 4'd0, 4'd0);
    chk("R1 code0", iss_ready, 0);
    present(3'd6, 4'd0, 4'd0, 4'd0);
    chk("R1 code6", iss_ready, 0);
    present(3'd7, 4'd0, 4'd0, 4'd0);
    chk("R1 code7", iss_ready, 0);
  endtask

  task automatic t_basic();
    issue(3'd1, 4'd1, 4'd2, 4'd3);
    chk("R4 read next cycle", rd_grant, 5'b00001);
    chk("R4 op latched", unit_op[3:0], 4'd1);
    step();
    chk("R4 read pulse", rd_grant, 0);
    done_pulse(5'b00001);
    chk("R7 wb", wb_grant, 5'b00001);
    chk("R7 wb_dst", wb_dst, 4'd1);
    step();
    chk("R7 wb pulse", wb_grant, 0);
    present(3'd1, 4'd1, 4'd0, 4'd0);
    chk("R10 unit free", iss_ready, 1);
  endtask

  task automatic t_struct_and_prio();
    issue(3'd2, 4'd4, 4'd2, 4'd3);
    step();
    present(3'd2, 4'd6, 4'd0, 4'd0);
    chk("R2 busy unit", iss_ready, 0);
    present(3'd3, 4'd6, 4'd0, 4'd0);
    chk("R2 other unit", iss_ready, 1);
    issue(3'd3, 4'd7, 4'd2, 4'd3);
    chk("R4 mult2 read", rd_grant, 5'b00100);
    step();
    done_pulse(5'b00110);
    chk("R9 lowest first", wb_grant, 5'b00010);
    chk("R9 dst first", wb_dst, 4'd4);
    step();
    chk("R9 second", wb_grant, 5'b00100);
    chk("R9 dst second", wb_dst, 4'd7);
    step();
    chk("R9 drained", wb_grant, 0);
  endtask

  task automatic t_parallel_read();
    issue(3'd4, 4'd11, 4'd1, 4'd2);
    step();
    issue(3'd2, 4'd12, 4'd11, 4'd1);
    chk("R4 RAW wait a", rd_grant, 0);
    issue(3'd3, 4'd13, 4'd11, 4'd11);
    chk("R4 RAW wait b", rd_grant, 0);
    done_pulse(5'b01000);
    chk("R7 producer wb", wb_grant, 5'b01000);
    chk("R4 no read during wb", rd_grant, 0);
    step();
    chk("R5 parallel read", rd_grant, 5'b00110);
    step();
    done_pulse(5'b00110);
    chk("R9 a", wb_grant, 5'b00010);
    step();
    chk("R9 b", wb_grant, 5'b00100);
    step();
  endtask

  task automatic t_waw_hold();
    issue(3'd4, 4'd5, 4'd1, 4'd2);
    step();
    present(3'd5, 4'd6, 4'd1, 4'd2);
    chk("R3 other dst", iss_ready, 1);
    present(3'd5, 4'd5, 4'd1, 4'd2);
    iss_valid = 1'b1;
    #1;
    chk("R3 waw stall", iss_ready, 0);
    step();
    chk("R1 held not moved", rd_grant, 0);
    chk("R3 still stalled", iss_ready, 0);
    exe_done = 5'b01000;
    step();
    exe_done = 5'd0;
    chk("R7 add wb", wb_grant, 5'b01000);
    chk("R10 before wb edge", iss_ready, 0);
    step();
    chk("R10 dst released", iss_ready, 1);
    step();
    iss_valid = 1'b0;
    chk("R1 held transfers", rd_grant, 5'b10000);
    step();
    done_pulse(5'b10000);
    chk("R7 div wb", wb_grant, 5'b10000);
    step();
  endtask

  task automatic t_war();
    issue(3'd5, 4'd0, 4'd2, 4'd4);
    chk("R4 div read", rd_grant, 5'b10000);
    step();
    issue(3'd4, 4'd10, 4'd0, 4'd8);
    chk("R4 add waits div", rd_grant, 0);
    issue(3'd1, 4'd8, 4'd8, 4'd14);
    chk("R4 sub reads", rd_grant, 5'b00001);
    step();
    done_pulse(5'b00001);
    chk("R8 sub wb held", wb_grant, 0);
    step();
    chk("R8 sub still held", wb_grant, 0);
    done_pulse(5'b10000);
    chk("R7 div wb", wb_grant, 5'b10000);
    step();
    chk("R4 add reads after div", rd_grant, 5'b01000);
    chk("R8 held during add read", wb_grant, 0);
    step();
    chk("R8 sub released", wb_grant, 5'b00001);
    chk("R8 sub dst", wb_dst, 4'd8);
    step();
    done_pulse(5'b01000);
    chk("R7 add wb", wb_grant, 5'b01000);
    step();
  endtask

  task automatic t_ignored_done();
    done_pulse(5'b11111);
    chk("R6 idle done ignored", wb_grant, 0);
    issue(3'd4, 4'd14, 4'd1, 4'd1);
    step();
    issue(3'd2, 4'd15, 4'd14, 4'd1);
    done_pulse(5'b00010);
    chk("R6 waiting done ignored", wb_grant, 0);
    done_pulse(5'b01000);
    chk("R6 add wb", wb_grant, 5'b01000);
    step();
    chk("R6 unit still reads", rd_grant, 5'b00010);
    step();
    done_pulse(5'b00010);
    chk("R6 honoured after read", wb_grant, 5'b00010);
    step();
  endtask

  task automatic t_same_cycle();
    issue(3'd3, 4'd1, 4'd2, 4'd2);
    step();
    done_pulse(5'b00100);
    chk("R11 producer wb", wb_grant, 5'b00100);
    issue(3'd1, 4'd3, 4'd1, 4'd2);
    chk("R11 consumer reads", rd_grant, 5'b00001);
    step();
    done_pulse(5'b00001);
    chk("R11 consumer wb", wb_grant, 5'b00001);
    step();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step();
    t_reset();
    t_basic();
    t_struct_and_prio();
    t_parallel_read();
    t_waw_hold();
    t_war();
    t_ignored_done();
    t_same_cycle();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #800000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule